// File: doc/BRIEF.md
# Serial Character Transmitter with Selectable Framing

This block serializes one character at a time onto an asynchronous serial line. The host places a character on a write port while the block signals it can take one. The block then shifts it out least significant bit first, inside a frame made of a low start bit, five to eight data bits, an optional parity bit and a stop interval that can be a fraction of a bit time. All bit timing comes from a baud tick pulse at sixteen times the bit rate, supplied from outside. A single holding register lets the host queue the next character while the current one is still on the line, so frames can follow each other with no idle gap.

A small command port enables or disables the transmitter, aborts all activity, and starts or ends a continuous break (the line held low). Two status flags tell the host when a write will be taken and when the line has gone fully quiet.

Top module: `uart_tx_framer`

## Requirements
- R1: After reset the line `txd` is high, `tx_empty` is high and `tx_ready` is low, because the transmitter starts disabled.
- R2: A frame is a low start bit followed by the data bits, least significant first. Each bit lasts 16 baud ticks. `cfg_len` selects the data bit count: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8.
- R3: `cfg_par` selects the bit sent after the data. 0 sends no parity bit. 1 sends odd parity, so the data ones plus the parity bit make an odd count. 2 sends even parity. 3 always sends 0. A parity bit lasts 16 ticks.
- R4: `cfg_stop` sets how long the line is high after the last data or parity bit before another start bit may begin: 0 gives 9 ticks, 1 gives 16, 2 gives 25 and 3 gives 32. A queued character starts right at the end of that interval.
- R5: `tx_ready` is high while the transmitter is enabled and the holding register is free. A write (`wr_valid` high with `tx_ready` high) fills the register and drops `tx_ready` on the next cycle. A `wr_valid` pulse while `tx_ready` is low is dropped.
- R6: `tx_empty` is high only when no character is shifting and none is held. Whenever it is high, `txd` is high.
- R7: Command 8 enables the transmitter and command 9 disables it. While disabled, `tx_ready` is low from the next cycle and writes are dropped. A frame already in progress still completes.
- R8: Command 5 drives `txd` low from the next cycle, even in the middle of a frame, and abandons that frame. Command 6 ends a break. The line then stays high for at least 16 ticks before a queued character starts. Command 6 outside a break has no effect.
- R9: Command 2 drops both the character being shifted and the held character, and ends any break. From the next cycle `txd` is high and `tx_empty` is high. No further start bit follows.
- R10: The framing fields are captured when a frame starts. Changing `cfg_len`, `cfg_par` or `cfg_stop` during a frame does not alter that frame.
- R11: Command codes other than 2, 5, 6, 8 and 9 have no effect on a frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| cfg_len | input | 2 | Data bit count select |
| cfg_par | input | 2 | Parity mode select |
| cfg_stop | input | 2 | Stop interval select |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 4 | Command code |
| wr_valid | input | 1 | Character write strobe |
| wr_data | input | 8 | Character to send |
| txd | output | 1 | Serial line, idle high |
| tx_ready | output | 1 | Holding register free and transmitter enabled |
| tx_empty | output | 1 | Nothing shifting and nothing held |

## Verification
A wrong bit counter or a wrong captured length shows within one frame. The tick-sampled line gains or loses a 16-tick slice, and the stop interval of the next frame appears to move. A fault in the stop duration selection shows only when two frames are sent back to back, because the second start bit lands off its expected tick. A holding register that fails to clear or fill shows on `tx_ready` one cycle after a write, or as a missing or duplicated frame once the line has settled. A break or reset that does not reach the state machine at once shows on `txd` in the very next cycle.

// File: rtl/uart_tx_framer.sv
module uart_tx_framer #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic [1:0] cfg_len,
  input  logic [1:0] cfg_par,
  input  logic [1:0] cfg_stop,
  input  logic       cmd_valid,
  input  logic [3:0] cmd_code,
  input  logic       wr_valid,
  input  logic [7:0] wr_data,
  output logic       txd,
  output logic       tx_ready,
  output logic       tx_empty
);

  localparam int CW = $clog2(2 * OVS);
  localparam logic [CW:0] STOP_Q0 = (CW + 1)'((OVS * 9) / 16);
  localparam logic [CW:0] STOP_Q1 = (CW + 1)'(OVS);
  localparam logic [CW:0] STOP_Q2 = (CW + 1)'((OVS * 25) / 16);
  localparam logic [CW:0] STOP_Q3 = (CW + 1)'(2 * OVS);

  localparam logic [3:0] C_RESET  = 4'd2;
  localparam logic [3:0] C_BRK_ON = 4'd5;
  localparam logic [3:0] C_BRK_OF = 4'd6;
  localparam logic [3:0] C_EN     = 4'd8;
  localparam logic [3:0] C_DIS    = 4'd9;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_BRK, S_GAP
  } st_t;

  st_t         state;
  logic [CW-1:0] cnt;
  logic [2:0]  bitn;
  logic [7:0]  shreg;
  logic        par_acc;
  logic [1:0]  f_len, f_par, f_stop;
  logic [7:0]  hold;
  logic        hold_full;
  logic        tx_en;

  logic [CW:0]   dur;
  logic [CW-1:0] dur_m1;
  logic [2:0]    nbits_m1;
  logic          last, par_bit, accept, go, kill, timed;

  always_comb begin
    unique case (f_stop)
      2'd0: dur = STOP_Q0;
      2'd1: dur = STOP_Q1;
      2'd2: dur = STOP_Q2;
      default: dur = STOP_Q3;
    endcase
    if (state != S_STOP) dur = (CW + 1)'(OVS);
  end

  assign dur_m1   = CW'(dur - 1'b1);
  assign nbits_m1 = 3'd4 + {1'b0, f_len};
  assign timed    = (state == S_START) || (state == S_DATA) || (state == S_PAR) ||
                    (state == S_STOP)  || (state == S_GAP);
  assign last     = baud_tick && timed && (cnt == dur_m1);
  assign par_bit  = (f_par == 2'd1) ? ~par_acc : (f_par == 2'd2) ? par_acc : 1'b0;
  assign kill     = cmd_valid && (cmd_code == C_RESET || cmd_code == C_BRK_ON);
  assign go       = hold_full && !kill &&
                    ((state == S_IDLE && baud_tick) ||
                     (last && (state == S_STOP || state == S_GAP)));

  assign tx_ready = tx_en && !hold_full;
  assign accept   = wr_valid && tx_ready;
  assign tx_empty = (state == S_IDLE) && !hold_full;

  always_comb begin
    unique case (state)
      S_START, S_BRK: txd = 1'b0;
      S_DATA:         txd = shreg[0];
      S_PAR:          txd = par_bit;
      default:        txd = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      bitn      <= '0;
      shreg     <= '0;
      par_acc   <= 1'b0;
      f_len     <= '0;
      f_par     <= '0;
      f_stop    <= '0;
      hold      <= '0;
      hold_full <= 1'b0;
      tx_en     <= 1'b0;
    end else begin
      if (accept) begin
        hold      <= wr_data;
        hold_full <= 1'b1;
      end
      if (baud_tick && timed) cnt <= last ? '0 : cnt + 1'b1;

      unique case (state)
        S_START: if (last) begin
          state <= S_DATA;
          bitn  <= '0;
        end
        S_DATA: if (last) begin
          shreg   <= shreg >> 1;
          par_acc <= par_acc ^ shreg[0];
          if (bitn == nbits_m1) state <= (f_par != 2'd0) ? S_PAR : S_STOP;
          else bitn <= bitn + 1'b1;
        end
        S_PAR:  if (last) state <= S_STOP;
        S_STOP: if (last) state <= S_IDLE;
        S_GAP:  if (last) state <= S_IDLE;
        default: ;
      endcase

      if (go) begin
        state     <= S_START;
        cnt       <= '0;
        shreg     <= hold;
        hold_full <= 1'b0;
        par_acc   <= 1'b0;
        f_len     <= cfg_len;
        f_par     <= cfg_par;
        f_stop    <= cfg_stop;
      end

      if (cmd_valid) begin
        unique case (cmd_code)
          C_EN:  tx_en <= 1'b1;
          C_DIS: tx_en <= 1'b0;
          C_RESET: begin
            state     <= S_IDLE;
            cnt       <= '0;
            hold_full <= 1'b0;
          end
          C_BRK_ON: begin
            state <= S_BRK;
            cnt   <= '0;
          end
          C_BRK_OF: if (state == S_BRK) begin
            state <= S_GAP;
            cnt   <= '0;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/uart_tx_framer_chk.sv
module uart_tx_framer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [3:0] cmd_code,
  input logic       wr_valid,
  input logic       txd,
  input logic       tx_ready,
  input logic       tx_empty
);

  // R8
  brk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_code == 4'd5 |=> !txd);

  // R9
  rst_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_code == 4'd2 |=> txd && tx_empty);

  // R6
  empty_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> txd);

  // R7
  dis_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_code == 4'd9 |=> !tx_ready);

  // R5
  accept_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && tx_ready && !(cmd_valid && cmd_code == 4'd2) |=> !tx_ready && !tx_empty);

endmodule

bind uart_tx_framer uart_tx_framer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
  .wr_valid(wr_valid), .txd(txd), .tx_ready(tx_ready), .tx_empty(tx_empty)
);

// File: tb/tb_uart_tx_framer.sv
module tb_uart_tx_framer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic [1:0] cfg_len = 2'd3, cfg_par = 2'd0, cfg_stop = 2'd1;
  logic       cmd_valid = 1'b0;
  logic [3:0] cmd_code = 4'd0;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = 8'd0;
  logic       txd, tx_ready, tx_empty;

  int checks = 0, failures = 0;
  logic smp [0:8191];
  int   ns = 0;
  bit   rec = 1'b0;
  logic [1:0] div = 2'd0;

  uart_tx_framer dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
    .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_stop(cfg_stop),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .wr_valid(wr_valid), .wr_data(wr_data),
    .txd(txd), .tx_ready(tx_ready), .tx_empty(tx_empty)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    div       <= div + 2'd1;
    baud_tick <= (div == 2'd3);
  end

  always @(negedge clk)
    if (rec && baud_tick && ns < 8192) begin
      smp[ns] = txd;
      ns++;
    end

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  function automatic int find_start(input int from);
    for (int i = from; i < ns; i++) if (smp[i] === 1'b0) return i;
    return -1;
  endfunction

  function automatic int run_cmp(input int pos, input logic v, input int n);
    int bad = 0;
    for (int k = 0; k < n; k++)
      if (pos + k < 0 || pos + k >= ns || smp[pos + k] !== v) bad++;
    return bad;
  endfunction

  task automatic chk_frame(input int at, input logic [7:0] d, input logic [1:0] len,
                           input logic [1:0] par, input logic [1:0] stp,
                           input string rq, output int nxt);
    int pos = at, bad = 0, nb = 5 + int'(len);
    logic p = 1'b0;
    int st;
    bad += run_cmp(pos, 1'b0, 16); pos += 16;
    for (int i = 0; i < nb; i++) begin
      bad += run_cmp(pos, d[i], 16); pos += 16;
      p ^= d[i];
    end
    if (par != 2'd0) begin
      bad += run_cmp(pos, (par == 2'd1) ? ~p : (par == 2'd2) ? p : 1'b0, 16);
      pos += 16;
    end
    st = (stp == 2'd0) ? 9 : (stp == 2'd1) ? 16 : (stp == 2'd2) ? 25 : 32;
    bad += run_cmp(pos, 1'b1, st); pos += st;
    chk(bad == 0 && at >= 0, rq, "frame mismatched tick samples", bad, 0);
    nxt = pos;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      while (!baud_tick) @(posedge clk);
    end
    #1;
  endtask

  task automatic send_cmd(input logic [3:0] c);
    cmd_valid = 1'b1; cmd_code = c;
    step();
    cmd_valid = 1'b0; cmd_code = 4'd0;
  endtask

  task automatic write_chr(input logic [7:0] d);
    int t = 0;
    while (!tx_ready && t < 20000) begin step(); t++; end
    wr_valid = 1'b1; wr_data = d;
    step();
    wr_valid = 1'b0;
  endtask

  task automatic wait_empty();
    int t = 0;
    while (!tx_empty && t < 20000) begin step(); t++; end
  endtask

  task automatic start_rec();
    ns = 0; rec = 1'b1;
  endtask

  task automatic t_reset();
    chk(txd === 1'b1, "R1", "txd after reset", int'(txd), 1);
    chk(tx_empty === 1'b1, "R1", "tx_empty after reset", int'(tx_empty), 1);
    chk(tx_ready === 1'b0, "R1", "tx_ready after reset", int'(tx_ready), 0);
    send_cmd(4'd8);
    chk(tx_ready === 1'b1, "R7", "tx_ready after enable", int'(tx_ready), 1);
  endtask

  task automatic t_pair(input logic [7:0] d0, input logic [7:0] d1, input logic [1:0] len,
                        input logic [1:0] par, input logic [1:0] stp, input string rq);
    int s, n1, n2;
    cfg_len = len; cfg_par = par; cfg_stop = stp;
    start_rec();
    write_chr(d0);
    write_chr(d1);
    wait_empty();
    wait_ticks(40);
    s = find_start(0);
    chk_frame(s, d0, len, par, stp, rq, n1);
    chk_frame(n1, d1, len, par, stp, rq, n2);
    chk(find_start(n2) == -1, rq, "extra start bit index", find_start(n2), -1);
  endtask

  task automatic t_hold();
    int s, n1, n2;
    cfg_len = 2'd3; cfg_par = 2'd0; cfg_stop = 2'd1;
    start_rec();
    write_chr(8'h81);
    wait_ticks(3);
    write_chr(8'h42);
    chk(tx_ready === 1'b0, "R5", "tx_ready with char held", int'(tx_ready), 0);
    chk(tx_empty === 1'b0, "R6", "tx_empty while busy", int'(tx_empty), 0);
    wr_valid = 1'b1; wr_data = 8'hFF; step(); wr_valid = 1'b0;
    wait_empty();
    chk(tx_empty === 1'b1 && txd === 1'b1, "R6", "empty and high after frames", int'(tx_empty), 1);
    wait_ticks(40);
    s = find_start(0);
    chk_frame(s, 8'h81, 2'd3, 2'd0, 2'd1, "R5", n1);
    chk_frame(n1, 8'h42, 2'd3, 2'd0, 2'd1, "R5", n2);
    chk(find_start(n2) == -1, "R5", "dropped write produced a frame", find_start(n2), -1);
  endtask

  task automatic t_cfg_mid();
    int s, n1;
    cfg_len = 2'd3; cfg_par = 2'd1; cfg_stop = 2'd1;
    start_rec();
    write_chr(8'hC6);
    wait_ticks(30);
    cfg_len = 2'd0; cfg_par = 2'd2; cfg_stop = 2'd3;
    send_cmd(4'd7);
    send_cmd(4'd12);
    wait_empty();
    wait_ticks(40);
    s = find_start(0);
    chk_frame(s, 8'hC6, 2'd3, 2'd1, 2'd1, "R10", n1);
    chk(find_start(n1) == -1, "R11", "unknown commands disturbed line", find_start(n1), -1);
  endtask

  task automatic t_disable();
    int s, n1;
    cfg_len = 2'd3; cfg_par = 2'd0; cfg_stop = 2'd1;
    start_rec();
    write_chr(8'h3A);
    wait_ticks(20);
    send_cmd(4'd9);
    chk(tx_ready === 1'b0, "R7", "tx_ready while disabled", int'(tx_ready), 0);
    wr_valid = 1'b1; wr_data = 8'h99; step(); wr_valid = 1'b0;
    wait_empty();
    wait_ticks(60);
    s = find_start(0);
    chk_frame(s, 8'h3A, 2'd3, 2'd0, 2'd1, "R7", n1);
    chk(find_start(n1) == -1, "R7", "write while disabled started a frame", find_start(n1), -1);
    send_cmd(4'd8);
  endtask

  task automatic t_break();
    int gap_at, s, n1;
    cfg_len = 2'd3; cfg_par = 2'd0; cfg_stop = 2'd1;
    start_rec();
    write_chr(8'h55);
    wait_ticks(40);
    send_cmd(4'd5);
    chk(txd === 1'b0, "R8", "txd right after break start", int'(txd), 0);
    wait_ticks(200);
    chk(txd === 1'b0, "R8", "txd held in break", int'(txd), 0);
    send_cmd(4'd6);
    gap_at = ns;
    write_chr(8'h0F);
    wait_empty();
    wait_ticks(40);
    chk(smp[gap_at - 1] === 1'b0, "R8", "line low before break end", int'(smp[gap_at - 1]), 0);
    s = find_start(gap_at);
    chk(s - gap_at >= 16 && s - gap_at <= 17, "R8", "high ticks after break", s - gap_at, 16);
    chk_frame(s, 8'h0F, 2'd3, 2'd0, 2'd1, "R8", n1);
    send_cmd(4'd6);
    chk(txd === 1'b1 && tx_empty === 1'b1, "R8", "break end while idle", int'(txd), 1);
  endtask

  task automatic t_abort();
    int snap;
    cfg_len = 2'd3; cfg_par = 2'd0; cfg_stop = 2'd1;
    start_rec();
    write_chr(8'h00);
    wait_ticks(3);
    write_chr(8'h00);
    wait_ticks(50);
    send_cmd(4'd2);
    snap = ns;
    chk(txd === 1'b1, "R9", "txd after transmitter reset", int'(txd), 1);
    chk(tx_empty === 1'b1, "R9", "tx_empty after transmitter reset", int'(tx_empty), 1);
    wait_ticks(300);
    chk(find_start(snap) == -1, "R9", "start bit after reset", find_start(snap), -1);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    step();
    t_reset();
    t_pair(8'hA5, 8'h3C, 2'd3, 2'd0, 2'd1, "R2");
    t_pair(8'h1B, 8'h0E, 2'd0, 2'd1, 2'd0, "R4");
    t_pair(8'h2D, 8'h33, 2'd1, 2'd2, 2'd2, "R3");
    t_pair(8'h7F, 8'h40, 2'd2, 2'd3, 2'd3, "R3");
    t_pair(8'hF0, 8'h07, 2'd3, 2'd2, 2'd0, "R4");
    t_hold();
    t_cfg_mid();
    t_disable();
    t_break();
    t_abort();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule